// File: doc/BRIEF.md
# Serial ADC Sampling Controller

This block paces a 16-bit serial analog-to-digital converter at a fixed rate so that a position control loop gets a new feedback sample on a rigid schedule. It splits time into frames of a constant number of clocks. At the start of each frame it raises the conversion-start line and holds it high while the converter digitizes. It then lowers that line and clocks the result out with sixteen serial clock pulses, most significant bit first. The assembled word appears on a parallel bus with a single-cycle valid strobe. The rest of the frame is idle, so the sample period never varies.

With the default 6.25 MHz clock and a 69-clock frame, a sample arrives every 11.04 µs. That rate sets the pace of the downstream control loop. The output is a stream with a valid signal and no ready signal. The converter cannot be stalled once a frame is under way, so the consumer gets no back-pressure. It must take the word in the cycle the strobe is high. After that it may read the held word at any time until the next strobe.

The converter is expected to present each bit while the serial clock is low and to change it only after a falling serial clock edge. The conversion-start line falling presents the first bit.

Top module: `adc_sample_ctrl`

## Requirements
- R1: While reset is asserted, conversion-start, serial clock and sample-valid are low and the sample word is zero.
- R2: Frames repeat every FRAME_CYCLES clocks (69 by default). Conversion-start is high for the first CONV_CYCLES clocks of each frame (20 by default). The first frame begins on the first clock edge after reset is released.
- R3: After conversion-start falls, exactly DATA_W (16) serial clock pulses follow. Each pulse is one clock low and then one clock high. The serial clock is never high while conversion-start is high.
- R4: The data line is sampled at the clock edge that ends each high serial clock cycle. The first bit taken becomes bit 15 (MSB) of the word and the last becomes bit 0.
- R5: Sample-valid is high for exactly one clock, in frame cycle CONV_CYCLES+2*DATA_W (cycle 52 by default). Frame cycle 0 is the first cycle with conversion-start high.
- R6: The sample word holds its value between strobes. Toggling of the data line while conversion-start is high or during the idle part of the frame has no effect on the word.
- R7: Consecutive valid strobes are exactly FRAME_CYCLES clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock (6.25 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_conv_o | output | 1 | Conversion-start / chip-select to the converter, high while converting |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| smp_data_o | output | DATA_W (16) | Most recent sample word |
| smp_valid_o | output | 1 | One-cycle strobe marking a new sample word |

## Verification
The assertions check several rules on every cycle. The frame counter stays in range, conversion-start falls at the right frame position, and the serial clock never overlaps conversion-start. The strobe lasts one cycle and follows the end of the shift window. The word never moves outside a strobe. Only the bench's scenarios can show that the bits land in MSB-first order with the right values, and that data-line noise outside the shift window is ignored. The bench also measures the strobe spacing and the frame start after a reset in mid-shift.

// File: rtl/adc_samp_pkg.sv
`timescale 1ns/1ps
package adc_samp_pkg;

  typedef enum logic [1:0] {
    PH_CONV   = 2'd0,
    PH_CLK_LO = 2'd1,
    PH_CLK_HI = 2'd2,
    PH_IDLE   = 2'd3
  } frame_phase_e;

  // Phase of a given frame position: conversion, shift (low/high halves), idle.
  function automatic frame_phase_e phase_at(input int unsigned pos,
                                            input int unsigned conv_len,
                                            input int unsigned n_bits);
    int unsigned off;
    if (pos < conv_len) return PH_CONV;
    if (pos < conv_len + 2 * n_bits) begin
      off = pos - conv_len;
      return off[0] ? PH_CLK_HI : PH_CLK_LO;
    end
    return PH_IDLE;
  endfunction

endpackage

// File: rtl/adc_frame_timer.sv
`timescale 1ns/1ps
module adc_frame_timer
  import adc_samp_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 69,
  parameter int unsigned CONV_CYCLES  = 20,
  parameter int unsigned DATA_W       = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic conv_o,
  output logic sclk_o,
  output logic capture_o,
  output logic last_o
);

  localparam int unsigned CNT_W     = $clog2(FRAME_CYCLES);
  localparam int unsigned SHIFT_END = CONV_CYCLES + 2 * DATA_W;

  generate
    if (FRAME_CYCLES <= SHIFT_END) begin : g_bad_frame
      $error("frame too short for conversion plus shift");
    end
  endgenerate

  logic [CNT_W-1:0] cnt_q, cnt_d;
  frame_phase_e     ph_now, ph_next;

  always_comb begin
    if (cnt_q == CNT_W'(FRAME_CYCLES - 1)) cnt_d = '0;
    else                                   cnt_d = cnt_q + 1'b1;
    ph_now  = phase_at(32'(cnt_q), CONV_CYCLES, DATA_W);
    ph_next = phase_at(32'(cnt_d), CONV_CYCLES, DATA_W);
  end

  // Counter parks on the last idle slot in reset, so frame 0 opens on the first edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(FRAME_CYCLES - 1);
      conv_o <= 1'b0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      conv_o <= (ph_next == PH_CONV);
      sclk_o <= (ph_next == PH_CLK_HI);
    end
  end

  assign capture_o = (ph_now == PH_CLK_HI);
  assign last_o    = (cnt_q == CNT_W'(SHIFT_END - 1));

  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(FRAME_CYCLES));

  p_conv_fall_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> cnt_q == CNT_W'(CONV_CYCLES));

  p_sclk_not_in_conv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !sclk_o);

endmodule

// File: rtl/adc_bit_shifter.sv
`timescale 1ns/1ps
module adc_bit_shifter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              capture_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int unsigned BC_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_next;
  logic [BC_W-1:0]   bits_q;
  logic              word_done;

  assign sr_next   = {sr_q[DATA_W-2:0], sdo_i};
  assign word_done = capture_i && (bits_q == BC_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      bits_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= word_done;
      if (start_i) begin
        bits_q <= '0;
      end else if (capture_i) begin
        sr_q   <= sr_next;
        bits_q <= word_done ? '0 : bits_q + 1'b1;
      end
      if (word_done) data_o <= sr_next;
    end
  end

  p_valid_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  p_capture_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> bits_q < BC_W'(DATA_W));

endmodule

// File: rtl/adc_sample_ctrl.sv
`timescale 1ns/1ps
module adc_sample_ctrl #(
  parameter int unsigned FRAME_CYCLES = 69,
  parameter int unsigned CONV_CYCLES  = 20,
  parameter int unsigned DATA_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adc_sdo_i,
  output logic              adc_conv_o,
  output logic              adc_sclk_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_valid_o
);

  logic capture;
  logic shift_last;

  adc_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .CONV_CYCLES (CONV_CYCLES),
    .DATA_W      (DATA_W)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .conv_o   (adc_conv_o),
    .sclk_o   (adc_sclk_o),
    .capture_o(capture),
    .last_o   (shift_last)
  );

  adc_bit_shifter #(
    .DATA_W(DATA_W)
  ) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (adc_conv_o),
    .capture_i(capture),
    .sdo_i    (adc_sdo_i),
    .data_o   (smp_data_o),
    .valid_o  (smp_valid_o)
  );

  // Bit count in the shifter and position in the timer must agree.
  p_last_gives_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_last |=> smp_valid_o);

  p_valid_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(shift_last));

  p_no_valid_in_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |-> !smp_valid_o);

endmodule

// File: tb/test_adc_sample_ctrl.sv
`timescale 1ns/1ps
module test_adc_sample_ctrl;

  localparam int FRAME = 69;
  localparam int CONV  = 20;
  localparam int DW    = 16;
  localparam int NVEC  = 8;
  localparam logic [DW-1:0] VEC [NVEC] = '{
    16'h0000, 16'hFFFF, 16'hA5A5, 16'h8001,
    16'h7FFE, 16'h1234, 16'hC3C3, 16'h0F0F
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sdo = 1'b0;
  logic          conv, sclk, valid;
  logic [DW-1:0] data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_sample_ctrl #(.FRAME_CYCLES(FRAME), .CONV_CYCLES(CONV), .DATA_W(DW)) i_adc_sample_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .adc_sdo_i(sdo),
    .adc_conv_o(conv), .adc_sclk_o(sclk),
    .smp_data_o(data), .smp_valid_o(valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Converter model: loads on conversion-start fall, advances on serial clock fall, noise otherwise.
  logic [DW-1:0] adc_word = '0;
  logic [DW-1:0] adc_sr = '0;
  logic          m_conv_p = 1'b0, m_sclk_p = 1'b0, shifting = 1'b0;
  int            nbits = 0;
  always @(negedge clk) begin
    if (m_conv_p && !conv) begin
      adc_sr = adc_word; sdo = adc_word[DW-1]; shifting = 1'b1; nbits = 0;
    end else if (m_sclk_p && !sclk && shifting) begin
      nbits++;
      if (nbits < DW) begin adc_sr = {adc_sr[DW-2:0], 1'b0}; sdo = adc_sr[DW-1]; end
      else shifting = 1'b0;
    end else if (!shifting) begin
      sdo = ~sdo;
    end
    m_conv_p = conv; m_sclk_p = sclk;
  end

  // Monitor.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int rise_cyc = 0, conv_len = 0, sclk_cnt = 0, lat = 0, period = 0, last_v = -1, overlap = 0;
  logic conv_p = 1'b0, sclk_p = 1'b0;
  event valid_ev;
  always @(negedge clk) begin
    if (!rst_n) begin
      last_v = -1; conv_p = 1'b0; sclk_p = 1'b0;
    end else begin
      if (conv && !conv_p) begin rise_cyc = cyc; conv_len = 0; sclk_cnt = 0; end
      if (conv) conv_len++;
      if (sclk && !sclk_p) sclk_cnt++;
      if (sclk && conv) overlap++;
      if (valid) begin
        lat = cyc - rise_cyc;
        period = (last_v < 0) ? FRAME : cyc - last_v;
        last_v = cyc;
        -> valid_ev;
      end
      conv_p = conv; sclk_p = sclk;
    end
  end

  initial begin
    adc_word = VEC[0];
    repeat (3) @(negedge clk);
    chk("R1 conv in reset", 32'(conv), 32'd0);
    chk("R1 sclk in reset", 32'(sclk), 32'd0);
    chk("R1 valid in reset", 32'(valid), 32'd0);
    chk("R1 data in reset", 32'(data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 frame opens on first edge", 32'(conv), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      @(valid_ev);
      if (i + 1 < NVEC) adc_word = VEC[i+1];
      chk("R4 MSB-first word", 32'(data), 32'(VEC[i]));
      chk("R5 strobe frame cycle", 32'(lat), 32'(CONV + 2*DW));
      chk("R2 conv high length", 32'(conv_len), 32'(CONV));
      chk("R3 sclk pulse count", 32'(sclk_cnt), 32'(DW));
      chk("R7 strobe spacing", 32'(period), 32'(FRAME));
      @(negedge clk);
      chk("R5 strobe width", 32'(valid), 32'd0);
      repeat (12) @(negedge clk);
      chk("R6 word held, noise ignored", 32'(data), 32'(VEC[i]));
    end
    chk("R3 sclk never with conv", 32'(overlap), 32'd0);

    // Reset in mid-shift, then a fresh frame.
    @(negedge clk iff sclk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 conv after mid reset", 32'(conv), 32'd0);
    chk("R1 sclk after mid reset", 32'(sclk), 32'd0);
    chk("R1 data after mid reset", 32'(data), 32'd0);
    adc_word = 16'hBEEF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 restart after reset", 32'(conv), 32'd1);
    @(valid_ev);
    chk("R4 word after reset", 32'(data), 32'hBEEF);
    chk("R5 strobe cycle after reset", 32'(lat), 32'(CONV + 2*DW));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule